// File: doc/BRIEF.md
# Fractional Modulus Controller for a Dual-Modulus Prescaler

This block produces the modulus-control bit that steers an N/N+1 dual-modulus prescaler in a synthesizer loop. Each transmitted FSK symbol then corresponds to a fixed fractional division ratio. The core is a synchronous binary up-counter that runs on the reference clock. When the count reaches all ones, a terminal-count flag is raised and the counter reloads an odd start word on the next edge. The start word is chosen by the symbol input.

The modulus-control output is the counter's least significant bit. Because the reload word is odd, that bit stays high across the reload instead of toggling. Each counter cycle therefore holds one more high state than low states. The low fraction per cycle sets the fractional part of the division ratio.

The symbol is taken in through a two-flop synchronizer and is read only at the reload edge. A change to the symbol therefore never alters a cycle that is already in progress. A symbol can be held for any number of cycles, and every cycle comes out identical, so the ratio has no drift even under long runs of equal bits.

Top module: `frac_modulus_ctrl`

## Requirements
- R1: A synchronous active-high reset loads the symbol-0 start word (default 5) into the counter and clears the synchronizer. While the reset is held and just after it is released, the modulus output equals that word's LSB (1) and the terminal-count flag is 0.
- R2: The counter advances by one on every clock. The terminal-count flag is high for exactly the one clock in which the count is all ones, and on that edge the counter reloads the selected start word.
- R3: The modulus output is the counter LSB. Within a cycle it inverts on every clock. Across the reload it stays at 1, both in the all-ones state and in the first state after it.
- R4: With symbol 0, the start word is 5 in the default 4-bit build. Each cycle then spans 11 states, from the first state after the reload through the terminal-count state, and the modulus output is low in 5 of them. In general, a word s in a b-bit counter gives 2^b−s states, of which (2^b−s−1)/2 are low.
- R5: With symbol 1, the start word is 7. This is the symbol-0 word with bit 1 set by the symbol. Each cycle spans 9 states, and the modulus output is low in 4 of them.
- R6: A symbol held constant gives identical cycles for any number of repetitions, with no change in cycle length or low count.
- R7: The symbol passes through a two-stage synchronizer and is used only at the reload edge. A change made 2 or more clocks before the terminal-count state ends takes effect at that reload. A change made 1 clock or less before it is deferred to the following reload. No change ever alters the cycle in progress.
- R8: The counter width and both start words are parameters. At elaboration, a start word that is even, or that is not below 2^b−1, is rejected, and so is a synchronizer shorter than 2 stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_in | input | 1 | Symbol to transmit, asynchronous to clk |
| mod_ctrl | output | 1 | Modulus-control bit to the prescaler (counter LSB) |
| wrap_flag | output | 1 | High during the all-ones count (the reload clock) |

## Verification
The bench builds the block with its default parameters: a 4-bit counter with start words 5 and 7, and a two-stage synchronizer. With these values the 11-state and 9-state cycles are short enough that each cycle's length, its low count and its toggle pattern can be measured directly, and runs of dozens of cycles fit well within the run time. The short cycles also let the bench place symbol changes exactly two and exactly one clock before the reload. This exercises both sides of the synchronizer's boundary, as well as changes made early in a cycle and changes made in the terminal-count state.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

   // number of counter states in one cycle for start word s in a w-bit counter
   function automatic int unsigned cyc_states(input int unsigned w, input int unsigned s);
      return (1 << w) - s;
   endfunction

   // states with the LSB low in that cycle
   function automatic int unsigned low_states(input int unsigned w, input int unsigned s);
      return ((1 << w) - s - 1) / 2;
   endfunction

   // true when a start word is usable: odd and below all-ones
   function automatic bit word_ok(input int unsigned w, input int unsigned s);
      return (s % 2 == 1) && (s < (1 << w) - 1);
   endfunction

endpackage

// File: rtl/fmc_din_sync.sv
module fmc_din_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic d_sync
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("fmc_din_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_async};
   end

   assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/fmc_word_sel.sv
module fmc_word_sel #(
   parameter int unsigned CNT_W     = 4,
   parameter int unsigned WORD_ZERO = 5,
   parameter int unsigned WORD_ONE  = 7
) (
   input  logic             sym,
   output logic [CNT_W-1:0] word
);
   localparam logic [CNT_W-1:0] W0   = CNT_W'(WORD_ZERO);
   localparam logic [CNT_W-1:0] W1   = CNT_W'(WORD_ONE);
   localparam logic [CNT_W-1:0] DIFF = W0 ^ W1;
   localparam bit SINGLE_BIT = (DIFF != '0) && ((DIFF & (DIFF - 1'b1)) == '0);

   generate
      if (SINGLE_BIT) begin : g_bit_insert
         // words differ in one position: the symbol drives that bit directly
         localparam logic [CNT_W-1:0] BASE = W0 & ~DIFF;
         localparam bit ONE_SETS = ((W1 & DIFF) != '0);
         always_comb begin
            word = BASE;
            if (sym == ONE_SETS) word = BASE | DIFF;
         end
      end else begin : g_full_mux
         always_comb word = sym ? W1 : W0;
      end
   endgenerate
endmodule

// File: rtl/fmc_count.sv
module fmc_count #(
   parameter int unsigned CNT_W    = 4,
   parameter int unsigned RST_WORD = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] load_word,
   output logic             lsb,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ALL_ONES = '1;
   localparam logic [CNT_W:0]   SPAN     = (CNT_W+1)'(1) << CNT_W;

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)       cnt <= CNT_W'(RST_WORD);
      else if (wrap) cnt <= load_word;
      else           cnt <= cnt + 1'b1;
   end

   assign wrap = (cnt == ALL_ONES);
   assign lsb  = cnt[0];

   // state tracker for the cycle-length property
   logic [CNT_W:0]   st_idx;
   logic [CNT_W-1:0] cur_word;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_idx   <= (CNT_W+1)'(1);
         cur_word <= CNT_W'(RST_WORD);
      end else if (wrap) begin
         st_idx   <= (CNT_W+1)'(1);
         cur_word <= load_word;
      end else begin
         st_idx   <= st_idx + 1'b1;
      end
   end

   // R2: terminal count lasts one clock
   p_wrap_single_r2: assert property (@(posedge clk) disable iff (rst)
      wrap |=> !wrap);

   // R3: LSB held high across the reload
   p_hold_high_r3: assert property (@(posedge clk) disable iff (rst)
      wrap |-> lsb ##1 lsb);

   // R3: LSB inverts on every clock inside a cycle
   p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
      !wrap |=> (lsb != $past(lsb)));

   // R7: the reloaded value is the word offered at the reload edge
   p_reload_word_r7: assert property (@(posedge clk) disable iff (rst)
      wrap |=> (cnt == $past(load_word)));

   // R4: cycle length equals 2^b minus the start word
   p_cycle_len_r4: assert property (@(posedge clk) disable iff (rst)
      wrap |-> (st_idx == SPAN - {1'b0, cur_word}));
endmodule

// File: rtl/frac_modulus_ctrl.sv
module frac_modulus_ctrl #(
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned WORD_ZERO   = 5,
   parameter int unsigned WORD_ONE    = 7,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic sym_in,
   output logic mod_ctrl,
   output logic wrap_flag
);
   import fmc_pkg::*;

   // R8: parameter legality
   generate
      if (CNT_W < 2 || CNT_W > 24) begin : g_bad_width
         $error("frac_modulus_ctrl: CNT_W out of range");
      end
      if (!word_ok(CNT_W, WORD_ZERO)) begin : g_bad_w0
         $error("frac_modulus_ctrl: WORD_ZERO must be odd and below all-ones");
      end
      if (!word_ok(CNT_W, WORD_ONE)) begin : g_bad_w1
         $error("frac_modulus_ctrl: WORD_ONE must be odd and below all-ones");
      end
   endgenerate

   logic             sym_s;
   logic [CNT_W-1:0] next_word;

   fmc_din_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async (sym_in),
      .d_sync  (sym_s)
   );

   fmc_word_sel #(
      .CNT_W     (CNT_W),
      .WORD_ZERO (WORD_ZERO),
      .WORD_ONE  (WORD_ONE)
   ) u_sel (
      .sym  (sym_s),
      .word (next_word)
   );

   fmc_count #(
      .CNT_W    (CNT_W),
      .RST_WORD (WORD_ZERO)
   ) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .load_word (next_word),
      .lsb       (mod_ctrl),
      .wrap      (wrap_flag)
   );
endmodule

// File: tb/frac_modulus_ctrl_tb.sv
module frac_modulus_ctrl_tb;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sym_in = 1'b0;
   logic mod_ctrl, wrap_flag;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   frac_modulus_ctrl u_dut (
      .clk       (clk),
      .rst       (rst),
      .sym_in    (sym_in),
      .mod_ctrl  (mod_ctrl),
      .wrap_flag (wrap_flag)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_wrap();
      int guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (!wrap_flag && guard < 100);
   endtask

   // starts in a wrap state; measures the next full cycle up to its wrap state
   // flip_at > 0 inverts sym_in when that state index is reached
   task automatic measure(input int flip_at, output int len, output int lows, output int bad);
      logic prev = mod_ctrl;
      len = 0; lows = 0; bad = 0;
      do begin
         @(negedge clk);
         len++;
         if (len == flip_at) sym_in = ~sym_in;
         if (!mod_ctrl) lows++;
         if (len == 1) begin
            if (mod_ctrl !== 1'b1) bad++;
         end else if (mod_ctrl === prev) bad++;
         if (wrap_flag && mod_ctrl !== 1'b1) bad++;
         prev = mod_ctrl;
      end while (!wrap_flag && len < 40);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      sym_in = 1'b0;
      repeat (3) @(negedge clk);
      check(mod_ctrl === 1'b1, "R1 mod in reset", mod_ctrl, 1);
      check(wrap_flag === 1'b0, "R1 wrap in reset", wrap_flag, 0);
      rst = 1'b0;
      check(mod_ctrl === 1'b1, "R1 mod after release", mod_ctrl, 1);
      // first cycle from reset: states 5..F -> 11 states including the reset state
      begin
         int n = 1;
         while (!wrap_flag && n < 40) begin
            @(negedge clk);
            n++;
         end
         check(n == 11, "R1 first cycle length", n, 11);
      end
   endtask

   task automatic t_sym(input logic v, input int exp_len, input int exp_low, input string req);
      int len, lows, bad;
      sym_in = v;
      wait_wrap();
      wait_wrap();
      for (int i = 0; i < 3; i++) begin
         measure(0, len, lows, bad);
         check(len == exp_len, {req, " cycle length"}, len, exp_len);
         check(lows == exp_low, {req, " low states"}, lows, exp_low);
         check(bad == 0, "R3 toggle pattern", bad, 0);
      end
   endtask

   task automatic t_dc(input logic v, input int exp_len, input int exp_low);
      int len, lows, bad, wrong;
      wrong = 0;
      sym_in = v;
      wait_wrap();
      wait_wrap();
      for (int i = 0; i < 40; i++) begin
         measure(0, len, lows, bad);
         if (len != exp_len || lows != exp_low || bad != 0) wrong++;
      end
      check(wrong == 0, "R6 long run of equal symbols", wrong, 0);
   endtask

   // flip at given state index of a cycle of known length; check this and next cycle
   task automatic t_flip(input int flip_at, input int exp_cur, input int exp_next, input string req);
      int len, lows, bad;
      wait_wrap();
      measure(flip_at, len, lows, bad);
      check(len == exp_cur, {req, " cycle with change"}, len, exp_cur);
      measure(0, len, lows, bad);
      check(len == exp_next, {req, " following cycle"}, len, exp_next);
   endtask

   initial begin
      t_reset();
      t_sym(1'b0, 11, 5, "R4");
      t_sym(1'b1, 9, 4, "R5");
      t_dc(1'b1, 9, 4);
      t_dc(1'b0, 11, 5);
      // sym is 0 now. R7: change in first state -> current stays 11, next 9
      t_flip(1, 11, 9, "R7 early");
      // sym is 1: change two states before the wrap state ends (index 9-2=7) -> next 11
      t_flip(7, 9, 11, "R7 two clocks before");
      // sym is 0: change one state before (index 11-1=10) -> next still 11
      t_flip(10, 11, 11, "R7 one clock before");
      // the deferred symbol 1 now applies
      begin
         int len, lows, bad;
         measure(0, len, lows, bad);
         check(len == 9, "R7 deferred change applied", len, 9);
         check(wrap_flag === 1'b1, "R2 wrap at cycle end", wrap_flag, 1);
         @(negedge clk);
         check(wrap_flag === 1'b0, "R2 wrap one clock", wrap_flag, 0);
      end
      // R7: change in the wrap state itself is deferred by a full cycle
      begin
         int len, lows, bad;
         wait_wrap();
         sym_in = 1'b0;
         measure(0, len, lows, bad);
         check(len == 9, "R7 change in wrap state deferred", len, 9);
         measure(0, len, lows, bad);
         check(len == 11, "R7 change in wrap state applied", len, 11);
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule